// File: doc/BRIEF.md
# Mailbox Request Sequencer

This block is the host-side engine for a command mailbox that sits behind a simple register bus. A caller supplies an operation (flash write, flash read, update authentication or power cycle), a dword address, a dword count of 1 to 16 and, for writes, the data. The sequencer then runs the whole exchange on the bus. For a write it loads the data registers and then issues the command word with the request bit set. It polls the command register until the target clears that bit, and it reads the status register. For a read that succeeds, it also fetches the requested dwords and streams them out.

The status code read back is turned into one of five error classes, and a missing completion before a deadline becomes a timeout. Flash reads and writes that fail are run again from the start, up to a fixed number of attempts in total. The end of every transaction is marked by a one-cycle completion pulse.

Register offsets on the bus are fixed: the data registers are at offsets 1 to 16, the command register is at 17 and the status register is at 18. The `wr_data` input must be held stable while `busy` is high.

Top module: `mbx_req_seq`

## Requirements
- R1: For a write (op_sel 0), the N data dwords go to offsets 1..N in ascending order (lane i of wr_data to offset 1+i) before the command word. The command word carries opcode 0 in bits [31:28] and N-1 in bits [27:24].
- R2: For a read (op_sel 2), the command word carries opcode 2 in bits [31:28] and N in bits [27:24] when N<16, with that field zero for N=16. Bit 1 is zero.
- R3: In a write command, bit 1 (header flag) is set exactly when the dword address is at or above HDR_BASE. Every command word carries the dword address in bits [23:2] and has bit 0 (request) set.
- R4: Authentication (op_sel 1) sends the word 0x10000001 and power cycle (op_sel 3) sends 0x40000001, with no data register writes.
- R5: After the command write, the sequencer reads offset 17 repeatedly until bit 0 reads zero, with POLL_GAP idle cycles between polls. It reads offset 18 once only after that.
- R6: Status bits [3:0] equal to 0 give err_code 0 (ok), 1 gives 1 (invalid), 2 gives 2 (access denied) and any other value gives 3 (I/O error). Bits [31:4] are ignored.
- R7: A poll that still reads busy after the deadline ends the attempt with err_code 4 (timeout). The deadline is LONG_CYC cycles for flash read/write and SHORT_CYC cycles for authentication and power cycle, counted from the command write.
- R8: A failed flash read or write attempt restarts from its first bus access, up to ATTEMPTS attempts in total, and the last attempt's code is reported. Authentication and power cycle are never repeated.
- R9: After a successful read, dwords from offsets 1..N appear in order on rd_data, each with a one-cycle rd_valid. A failed read produces no rd_valid.
- R10: After reset, done, fail, busy and bus_req are low. At the end of each transaction, done pulses for one cycle with busy low, fail is high in that cycle exactly when err_code is nonzero, and start is accepted only while busy is low.
- R11: Once raised, bus_req holds with stable bus_addr, bus_we and bus_wdata until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken when idle) |
| op_sel | input | 2 | 0 write, 1 authenticate, 2 read, 3 power cycle |
| dw_addr | input | 22 | Dword address |
| dw_cnt | input | 5 | Dword count, 1..16 |
| wr_data | input | 512 | Write data, lane i in bits [32i+31:32i] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| fail | output | 1 | One-cycle pulse with done when err_code is nonzero |
| err_code | output | 3 | Result class, valid with done |
| rd_valid | output | 1 | Read data beat strobe |
| rd_data | output | 32 | Read data beat |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 8 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle access acknowledge |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The checker watches the bus on every cycle. It confirms that a write command is preceded by exactly the number of data writes its count field implies, and that the status register is never read before a poll has shown the request bit clear. It also checks that requests are held until acknowledged, that rd_valid only rides on a data register read, and that done is a lone idle-time pulse that agrees with fail. The exact command encodings, the status translation, the poll spacing, the choice between the two deadlines and the retry counts depend on what the target returns, so only the bench scenarios can show them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    OPS_WRITE = 2'd0,
    OPS_AUTH  = 2'd1,
    OPS_READ  = 2'd2,
    OPS_PCYC  = 2'd3
  } op_sel_e;

  typedef enum logic [2:0] {
    E_OK      = 3'd0,
    E_INVAL   = 3'd1,
    E_ACCESS  = 3'd2,
    E_IO      = 3'd3,
    E_TIMEOUT = 3'd4
  } err_e;

  // Register offsets decoded by the mailbox target
  localparam int DATA_OFS = 1;
  localparam int CMD_OFS  = 17;
  localparam int STAT_OFS = 18;

  function automatic logic [3:0] opcode_of(op_sel_e s);
    case (s)
      OPS_WRITE: return 4'h0;
      OPS_AUTH:  return 4'h1;
      OPS_READ:  return 4'h2;
      default:   return 4'h4;
    endcase
  endfunction

  // Count field: writes carry n-1, reads carry n only below 16
  function automatic logic [3:0] count_field(op_sel_e s, logic [4:0] n);
    logic [4:0] m1;
    m1 = n - 5'd1;
    if (s == OPS_WRITE) return m1[3:0];
    if (s == OPS_READ)  return n[4] ? 4'h0 : n[3:0];
    return 4'h0;
  endfunction

  function automatic err_e map_status(logic [3:0] st);
    case (st)
      4'd0:    return E_OK;
      4'd1:    return E_INVAL;
      4'd2:    return E_ACCESS;
      default: return E_IO;
    endcase
  endfunction

  function automatic logic retryable(op_sel_e s);
    return (s == OPS_WRITE) || (s == OPS_READ);
  endfunction

endpackage

// File: rtl/mbx_word_build.sv
module mbx_word_build
  import mbx_pkg::*;
#(
  parameter logic [21:0] HDR_BASE = 22'h200000
) (
  input  op_sel_e     op,
  input  logic [21:0] addr,
  input  logic [4:0]  cnt,
  output logic [31:0] word
);
  logic hdr;
  assign hdr  = (op == OPS_WRITE) && (addr >= HDR_BASE);
  assign word = (op == OPS_WRITE || op == OPS_READ)
              ? {opcode_of(op), count_field(op, cnt), addr, hdr, 1'b1}
              : {opcode_of(op), 26'd0, 1'b0, 1'b1};
endmodule

// File: rtl/mbx_deadline.sv
module mbx_deadline #(
  parameter int LONG_CYC  = 400,
  parameter int SHORT_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic short_sel,
  output logic expired
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit   = short_sel ? CW'(SHORT_CYC) : CW'(LONG_CYC);
  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mbx_req_seq.sv
module mbx_req_seq
  import mbx_pkg::*;
#(
  parameter int          MAX_DW    = 16,
  parameter int          BUS_AW    = 8,
  parameter logic [21:0] HDR_BASE  = 22'h200000,
  parameter int          POLL_GAP  = 4,
  parameter int          LONG_CYC  = 400,
  parameter int          SHORT_CYC = 60,
  parameter int          ATTEMPTS  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           op_sel,
  input  logic [21:0]          dw_addr,
  input  logic [4:0]           dw_cnt,
  input  logic [MAX_DW*32-1:0] wr_data,
  output logic                 busy,
  output logic                 done,
  output logic                 fail,
  output logic [2:0]           err_code,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [BUS_AW-1:0]    bus_addr,
  output logic [31:0]          bus_wdata,
  input  logic                 bus_ack,
  input  logic [31:0]          bus_rdata
);
  localparam int LW = $clog2(MAX_DW);
  localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam int TW = $clog2(ATTEMPTS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WDATA, S_CMD, S_GAP, S_POLL, S_STAT, S_RDATA
  } st_e;

  st_e          state;
  op_sel_e      op_q;
  logic [21:0]  addr_q;
  logic [4:0]   cnt_q;
  logic [4:0]   idx_q;
  logic [GW-1:0] gap_q;
  logic [TW-1:0] tries_q;
  logic         done_q, fail_q;
  err_e         code_q;

  // Named internal events
  logic ev_cmd_sent, ev_poll_clear, ev_poll_busy, ev_stat_seen, tmo_hit;
  logic last_beat, attempt_bad, do_retry, finish;
  err_e stat_code, bad_code, fin_code;
  st_e  restart_state;
  logic [31:0] cmd_word;
  logic unused_rdata;

  assign unused_rdata = ^bus_rdata[31:4];

  mbx_word_build #(.HDR_BASE(HDR_BASE)) u_word (
    .op(op_q), .addr(addr_q), .cnt(cnt_q), .word(cmd_word)
  );

  mbx_deadline #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_deadline (
    .clk(clk), .rst_n(rst_n), .clear(ev_cmd_sent),
    .run(state == S_GAP || state == S_POLL),
    .short_sel(!retryable(op_q)), .expired(tmo_hit)
  );

  assign ev_cmd_sent   = (state == S_CMD)  && bus_ack;
  assign ev_poll_clear = (state == S_POLL) && bus_ack && !bus_rdata[0];
  assign ev_poll_busy  = (state == S_POLL) && bus_ack && bus_rdata[0];
  assign ev_stat_seen  = (state == S_STAT) && bus_ack;
  assign stat_code     = map_status(bus_rdata[3:0]);
  assign last_beat     = (idx_q == cnt_q - 5'd1);
  assign restart_state = (op_q == OPS_WRITE) ? S_WDATA : S_CMD;

  always_comb begin
    attempt_bad = 1'b0;
    bad_code    = E_OK;
    if (ev_poll_busy && tmo_hit) begin
      attempt_bad = 1'b1;
      bad_code    = E_TIMEOUT;
    end else if (ev_stat_seen && stat_code != E_OK) begin
      attempt_bad = 1'b1;
      bad_code    = stat_code;
    end
    do_retry = attempt_bad && retryable(op_q) && (tries_q < TW'(ATTEMPTS - 1));
    finish   = (attempt_bad && !do_retry)
            || (ev_stat_seen && stat_code == E_OK && op_q != OPS_READ)
            || (state == S_RDATA && bus_ack && last_beat);
    fin_code = attempt_bad ? bad_code : E_OK;
  end

  // Bus drive
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state)
      S_WDATA: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = BUS_AW'(DATA_OFS) + BUS_AW'(idx_q);
        bus_wdata = wr_data[idx_q[LW-1:0]*32 +: 32];
      end
      S_CMD: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = BUS_AW'(CMD_OFS);
        bus_wdata = cmd_word;
      end
      S_POLL: begin
        bus_req  = 1'b1;
        bus_addr = BUS_AW'(CMD_OFS);
      end
      S_STAT: begin
        bus_req  = 1'b1;
        bus_addr = BUS_AW'(STAT_OFS);
      end
      S_RDATA: begin
        bus_req  = 1'b1;
        bus_addr = BUS_AW'(DATA_OFS) + BUS_AW'(idx_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OPS_WRITE;
      addr_q  <= '0;
      cnt_q   <= 5'd1;
      idx_q   <= '0;
      gap_q   <= '0;
      tries_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      code_q  <= E_OK;
    end else begin
      done_q <= finish;
      fail_q <= finish && (fin_code != E_OK);
      if (finish) code_q <= fin_code;
      unique case (state)
        S_IDLE: if (start) begin
          op_q    <= op_sel_e'(op_sel);
          addr_q  <= dw_addr;
          cnt_q   <= dw_cnt;
          idx_q   <= '0;
          tries_q <= '0;
          state   <= (op_sel_e'(op_sel) == OPS_WRITE) ? S_WDATA : S_CMD;
        end
        S_WDATA: if (bus_ack) begin
          if (last_beat) begin
            idx_q <= '0;
            state <= S_CMD;
          end else idx_q <= idx_q + 5'd1;
        end
        S_CMD: if (bus_ack) begin
          gap_q <= '0;
          state <= S_GAP;
        end
        S_GAP: begin
          if (gap_q == GW'(POLL_GAP - 1)) state <= S_POLL;
          else gap_q <= gap_q + 1'b1;
        end
        S_POLL: if (bus_ack) begin
          if (!bus_rdata[0]) state <= S_STAT;
          else begin
            gap_q <= '0;
            state <= S_GAP;
          end
        end
        S_STAT: if (bus_ack && op_q == OPS_READ) begin
          idx_q <= '0;
          state <= S_RDATA;
        end
        S_RDATA: if (bus_ack && !last_beat) idx_q <= idx_q + 5'd1;
        default: state <= S_IDLE;
      endcase
      if (do_retry) begin
        tries_q <= tries_q + 1'b1;
        idx_q   <= '0;
        state   <= restart_state;
      end
      if (finish) state <= S_IDLE;
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign fail     = fail_q;
  assign err_code = code_q;
  assign rd_valid = (state == S_RDATA) && bus_ack;
  assign rd_data  = bus_rdata;

endmodule

// File: rtl/mbx_req_seq_chk.sv
module mbx_req_seq_chk #(
  parameter int BUS_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              fail,
  input logic [2:0]        err_code,
  input logic              busy,
  input logic              rd_valid,
  input logic              bus_req,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              ev_cmd_sent,
  input logic              ev_poll_clear
);
  logic [4:0] wr_seen;
  logic       clear_seen;
  logic       data_wr_ack, stat_rd_ack, cmd_wr_ack;

  assign data_wr_ack = bus_req && bus_ack && bus_we && bus_addr >= BUS_AW'(1) && bus_addr <= BUS_AW'(16);
  assign cmd_wr_ack  = bus_req && bus_ack && bus_we && bus_addr == BUS_AW'(17);
  assign stat_rd_ack = bus_req && bus_ack && !bus_we && bus_addr == BUS_AW'(18);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_seen    <= '0;
      clear_seen <= 1'b0;
    end else begin
      if (ev_cmd_sent) wr_seen <= '0;
      else if (data_wr_ack) wr_seen <= wr_seen + 5'd1;
      if (ev_cmd_sent) clear_seen <= 1'b0;
      else if (ev_poll_clear) clear_seen <= 1'b1;
    end
  end

  // R1: a write command follows exactly count+1 data writes
  a_r1_data_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_ack && bus_wdata[31:28] == 4'h0 |-> wr_seen == {1'b0, bus_wdata[27:24]} + 5'd1);

  // R5: status is read only after a poll showed the request bit clear
  a_r5_status_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_ack |-> clear_seen);

  // R9: read beats only come from data register reads
  a_r9_beat_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> bus_ack && !bus_we && bus_addr >= BUS_AW'(1) && bus_addr <= BUS_AW'(16));

  // R10: done is a single idle-time pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done && err_code != 3'd0);
  a_r10_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> err_code == 3'd0);

  // R11: request held stable until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

endmodule

bind mbx_req_seq mbx_req_seq_chk #(.BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fail(fail), .err_code(err_code),
  .busy(busy), .rd_valid(rd_valid), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .ev_cmd_sent(ev_cmd_sent), .ev_poll_clear(ev_poll_clear)
);

// File: tb/mbx_req_seq_tb.sv
`timescale 1ns/1ps
module mbx_req_seq_tb;
  localparam int POLL_GAP = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic [21:0]  dw_addr = '0;
  logic [4:0]   dw_cnt = 5'd1;
  logic [511:0] wr_data = '0;
  logic         busy, done, fail, rd_valid, bus_req, bus_we;
  logic [2:0]   err_code;
  logic [31:0]  rd_data, bus_wdata;
  logic [7:0]   bus_addr;
  logic         bus_ack;
  logic [31:0]  bus_rdata;

  always #5 clk = ~clk;

  mbx_req_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .dw_addr(dw_addr),
    .dw_cnt(dw_cnt), .wr_data(wr_data), .busy(busy), .done(done), .fail(fail),
    .err_code(err_code), .rd_valid(rd_valid), .rd_data(rd_data), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  int errors = 0;
  int checks = 0;

  // Target scenario knobs (written only by tasks, read by the target)
  int busy_polls;                 // -1 = never completes
  int status_seq [4];

  // Target model state and logs
  logic [31:0] tdata [17];
  logic [31:0] cmd_log [8];
  int   wat_cmd [8];
  int   wlog [64];
  int   n_cmd, n_w, n_poll, n_stat, polls_left, cyc;
  int   poll_cyc [64];
  logic t_ack;
  logic [31:0] t_rdata;

  assign bus_ack   = t_ack;
  assign bus_rdata = t_rdata;

  always @(posedge clk) begin
    cyc = cyc + 1;
    t_ack <= 1'b0;
    if (start && !busy) begin
      n_cmd = 0; n_w = 0; n_poll = 0; n_stat = 0;
    end
    if (bus_req && !t_ack) begin
      t_ack <= 1'b1;
      if (bus_we) begin
        if (bus_addr >= 8'd1 && bus_addr <= 8'd16) begin
          tdata[bus_addr] = bus_wdata;
          if (n_w < 64) wlog[n_w] = int'(bus_addr);
          n_w = n_w + 1;
        end else if (bus_addr == 8'd17) begin
          if (n_cmd < 8) begin
            cmd_log[n_cmd] = bus_wdata;
            wat_cmd[n_cmd] = n_w;
          end
          n_cmd = n_cmd + 1;
          polls_left = busy_polls;
        end
      end else begin
        if (bus_addr >= 8'd1 && bus_addr <= 8'd16) t_rdata <= tdata[bus_addr];
        else if (bus_addr == 8'd17) begin
          if (n_poll < 64) poll_cyc[n_poll] = cyc;
          n_poll = n_poll + 1;
          if (polls_left != 0) begin
            t_rdata <= cmd_log[0] | 32'h1;
            if (polls_left > 0) polls_left = polls_left - 1;
          end else t_rdata <= cmd_log[0] & ~32'h1;
        end else if (bus_addr == 8'd18) begin
          n_stat = n_stat + 1;
          t_rdata <= {24'h0, 4'hA, 4'(status_seq[(n_cmd > 4) ? 3 : n_cmd - 1])};
        end else t_rdata <= 32'h0;
      end
    end
  end

  // Output monitor away from the active edge
  int done_cnt = 0, done_wide = 0, rd_n = 0;
  logic prev_done = 1'b0;
  logic [2:0] last_code;
  logic last_fail;
  logic [31:0] rd_buf [32];

  always @(negedge clk) begin
    if (start) rd_n = 0;
    if (done) begin
      done_cnt  = done_cnt + 1;
      last_code = err_code;
      last_fail = fail;
      if (prev_done) done_wide = done_wide + 1;
    end
    prev_done = done;
    if (rd_valid) begin
      if (rd_n < 32) rd_buf[rd_n] = rd_data;
      rd_n = rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int opc, int cf, int addr, int hdr);
    return 32'(opc * (1 << 28) + cf * (1 << 24) + addr * 4 + hdr * 2 + 1);
  endfunction

  task automatic run(input int op, input int addr, input int cnt);
    int d0;
    int guard;
    d0 = done_cnt;
    @(posedge clk); #1;
    op_sel = 2'(op); dw_addr = 22'(addr); dw_cnt = 5'(cnt); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    guard = 0;
    while (done_cnt == d0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_cnt == d0 + 1, "R10 single done per transaction", done_cnt - d0, 1);
    chk(last_fail == (last_code != 3'd0), "R10 fail agrees with code", last_fail, last_code != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_wdata(input int seed);
    for (int i = 0; i < 16; i++) wr_data[i*32 +: 32] = 32'hC0DE0000 + 32'(seed * 256 + i);
  endtask

  task automatic t_reset;
    chk(!done && !busy && !bus_req && !fail, "R10 reset state", {done, busy, bus_req, fail}, 0);
  endtask

  task automatic t_write(input int addr, input int cnt, input int hdr);
    bit order_ok;
    busy_polls = 0; status_seq = '{0, 0, 0, 0};
    fill_wdata(cnt);
    run(0, addr, cnt);
    chk(last_code == 3'd0, "R1 write ok", last_code, 0);
    chk(n_cmd == 1 && wat_cmd[0] == cnt, "R1 data writes before command", wat_cmd[0], cnt);
    order_ok = 1'b1;
    for (int i = 0; i < cnt; i++)
      if (wlog[i] != i + 1 || tdata[i+1] != wr_data[i*32 +: 32]) order_ok = 1'b0;
    chk(order_ok, "R1 data order and content", order_ok, 1);
    chk(cmd_log[0] == exp_word(0, cnt - 1, addr, hdr), "R1 R3 write command word",
        cmd_log[0], exp_word(0, cnt - 1, addr, hdr));
  endtask

  task automatic t_read(input int cnt);
    bit data_ok;
    busy_polls = 1; status_seq = '{0, 0, 0, 0};
    for (int i = 1; i <= 16; i++) tdata[i] = 32'h5EED0000 + 32'(cnt * 64 + i);
    run(2, 22'h1234, cnt);
    chk(last_code == 3'd0, "R2 read ok", last_code, 0);
    chk(cmd_log[0] == exp_word(2, (cnt < 16) ? cnt : 0, 22'h1234, 0), "R2 read command word",
        cmd_log[0], exp_word(2, (cnt < 16) ? cnt : 0, 22'h1234, 0));
    chk(n_w == 0, "R2 no data writes on read", n_w, 0);
    chk(rd_n == cnt, "R9 beat count", rd_n, cnt);
    data_ok = 1'b1;
    for (int i = 0; i < cnt; i++)
      if (rd_buf[i] != 32'h5EED0000 + 32'(cnt * 64 + i + 1)) data_ok = 1'b0;
    chk(data_ok, "R9 beat data in order", data_ok, 1);
  endtask

  task automatic t_simple_cmds;
    busy_polls = 0; status_seq = '{0, 0, 0, 0};
    run(1, 22'h3FFFFF, 16);
    chk(cmd_log[0] == 32'h10000001 && n_w == 0, "R4 authenticate word", cmd_log[0], 32'h10000001);
    run(3, 22'h3FFFFF, 16);
    chk(cmd_log[0] == 32'h40000001 && n_w == 0, "R4 power cycle word", cmd_log[0], 32'h40000001);
    chk(last_code == 3'd0, "R4 power cycle ok", last_code, 0);
  endtask

  task automatic t_poll;
    busy_polls = 3; status_seq = '{0, 0, 0, 0};
    fill_wdata(7);
    run(0, 22'h40, 2);
    chk(n_poll == 4, "R5 polls until bit 0 clear", n_poll, 4);
    chk(poll_cyc[1] - poll_cyc[0] == POLL_GAP + 2, "R5 poll spacing",
        poll_cyc[1] - poll_cyc[0], POLL_GAP + 2);
    chk(n_stat == 1, "R5 single status read", n_stat, 1);
  endtask

  task automatic t_status(input int st, input int exp_code);
    busy_polls = 0; status_seq = '{st, 0, 0, 0};
    run(1, 0, 1);
    chk(last_code == 3'(exp_code), "R6 status translation", last_code, exp_code);
    chk(n_cmd == 1, "R8 authenticate not repeated", n_cmd, 1);
  endtask

  task automatic t_retry;
    busy_polls = 0; status_seq = '{2, 0, 0, 0};
    fill_wdata(3);
    run(0, 22'h80, 3);
    chk(last_code == 3'd0 && n_cmd == 2, "R8 write retried once then ok", n_cmd, 2);
    chk(n_w == 6 && wat_cmd[1] == 6, "R8 retry reloads data", n_w, 6);
    status_seq = '{1, 1, 1, 0};
    run(2, 22'h80, 4);
    chk(n_cmd == 3 && last_code == 3'd1, "R8 read gives up after three attempts", n_cmd, 3);
    chk(rd_n == 0, "R9 no beats on failed read", rd_n, 0);
  endtask

  task automatic t_timeout;
    busy_polls = 20; status_seq = '{0, 0, 0, 0};
    run(1, 0, 1);
    chk(last_code == 3'd4 && n_stat == 0, "R7 short deadline times out", last_code, 4);
    fill_wdata(9);
    run(0, 22'h10, 1);
    chk(last_code == 3'd0, "R7 long deadline tolerates slow target", last_code, 0);
    busy_polls = -1;
    run(0, 22'h10, 1);
    chk(last_code == 3'd4 && n_cmd == 3, "R7 R8 write timeout after all attempts", n_cmd, 3);
  endtask

  initial begin
    busy_polls = 0;
    status_seq = '{0, 0, 0, 0};
    n_cmd = 0; n_w = 0; n_poll = 0; n_stat = 0; polls_left = 0; cyc = 0;
    t_ack = 1'b0; t_rdata = '0;
    for (int i = 0; i < 17; i++) tdata[i] = '0;
    for (int i = 0; i < 8; i++) begin cmd_log[i] = '0; wat_cmd[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(22'h000100, 3, 0);
    t_write(22'h200000, 16, 1);
    t_write(22'h1FFFFF, 1, 0);
    t_read(5);
    t_read(16);
    t_simple_cmds();
    t_poll();
    t_status(1, 1);
    t_status(2, 2);
    t_status(3, 3);
    t_status(7, 3);
    t_retry();
    t_timeout();
    chk(done_wide == 0, "R10 done one cycle wide", done_wide, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule